// File: doc/BRIEF.md
# Queue Flag Status Multiplexer

This block reports the almost-full and almost-empty condition of every queue in a 32-queue buffer, including queues that neither port has selected. It does this over two 8-bit status buses. The per-queue flags arrive as two 32-bit vectors from the flag logic, which lies outside this block. Each bus carries one quadrant of eight queues at a time. The almost-full bus runs on the write clock and the almost-empty bus runs on the read clock.

One shared mode input picks how quadrants are chosen. In polled mode, each bus steps through the four quadrants on its own clock. In direct mode, each side latches a quadrant address from its own address inputs. Each bus is registered. Alongside the bus it drives a 2-bit quadrant index and a strobe that marks quadrant 1. A configured-queue count blanks the flag bits of unconfigured queues. When eight or fewer queues are configured, it pins both buses to the first quadrant.

Top module: `qflag_mux`

## Requirements
- R1: While `rstN` is low, both buses, both quadrant indexes and both strobes are 0.
- R2: After a clock edge, a bus showing quadrant index q (0 to 3) has bit b equal to flag bit 8*q+b of its flag vector, as sampled at that edge. Bit i of a flag vector belongs to queue i+1, so index 0 carries queues 1 to 8 and index 3 carries queues 25 to 32.
- R3: With `pollMode` high and more than 8 queues configured, the quadrant index steps 0, 1, 2, 3, 0 and so on. It moves once on every rising edge of that bus's own clock. The first edge after reset shows index 0.
- R4: A strobe is high exactly while its bus is showing quadrant index 0.
- R5: With `pollMode` low, a side loads its quadrant address on an edge where its address enable is high. Its bus shows that quadrant from the following edge on. Address changes made while the enable is low have no effect.
- R6: The two sides are independent. The write-side address only moves the almost-full bus, and the read-side address only moves the almost-empty bus. The single `pollMode` input sets the mode for both sides.
- R7: A bus bit whose queue number (8*q+b+1) is greater than `activeQueues` reads 0. Polled mode still visits all four quadrants when fewer than 32 queues are configured.
- R8: When `activeQueues` is 8 or less, both buses stay at quadrant index 0 in either mode. Each then shows one flag per configured queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock, drives the almost-full bus |
| rdClk | input | 1 | Read-side clock, drives the almost-empty bus |
| rstN | input | 1 | Asynchronous active-low reset |
| pollMode | input | 1 | 1 = polled stepping, 0 = direct addressing (both buses) |
| activeQueues | input | 6 | Number of configured queues, 0 to 32 |
| afFlags | input | 32 | Per-queue almost-full flags, bit i = queue i+1 |
| aeFlags | input | 32 | Per-queue almost-empty flags, bit i = queue i+1 |
| wrQuadAddr | input | 2 | Write-side quadrant address for direct mode |
| wrQuadAddrEn | input | 1 | Loads `wrQuadAddr` on a write clock edge |
| rdQuadAddr | input | 2 | Read-side quadrant address for direct mode |
| rdQuadAddrEn | input | 1 | Loads `rdQuadAddr` on a read clock edge |
| afBus | output | 8 | Almost-full status of the shown quadrant |
| afQuad | output | 2 | Quadrant index on `afBus` |
| afStrobe | output | 1 | High while `afBus` shows quadrant index 0 |
| aeBus | output | 8 | Almost-empty status of the shown quadrant |
| aeQuad | output | 2 | Quadrant index on `aeBus` |
| aeStrobe | output | 1 | High while `aeBus` shows quadrant index 0 |

## Verification
A corrupted polling pointer shows one edge later as a skipped or repeated quadrant index. The strobe then falls out of step with index 0. A stale direct address register leaves the index on the wrong quadrant one edge after the enabling cycle. A mis-sliced flag select or a wrong blanking mask shows up at once as wrong bus bits for the reported index. Every path is one register deep, so any such fault appears within one or two edges of the clock that owns it.

// File: rtl/qflag_pkg.sv
package qflag_pkg;
  localparam int LANES  = 8;
  localparam int QUADS  = 4;
  localparam int QUEUES = LANES * QUADS;
  localparam int QW     = $clog2(QUADS);
  localparam int IW     = $clog2(QUEUES);
  localparam int CW     = $clog2(QUEUES + 1);

  // strobes from a quadrant sequencer to its flag path
  typedef struct packed {
    logic [QW-1:0] quad;
    logic          first;
  } quadSel_t;
endpackage

// File: rtl/qflag_ctrl.sv
module qflag_ctrl
  import qflag_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pollMode,
  input  logic [CW-1:0] activeQueues,
  input  logic [QW-1:0] quadAddr,
  input  logic          quadAddrEn,
  output quadSel_t      sel
);
  logic [QW-1:0] pollPtr;
  logic [QW-1:0] dirQuad;
  logic          singleQuad;

  assign singleQuad = (activeQueues <= CW'(LANES));

  always_comb begin
    if (singleQuad)    sel.quad = '0;
    else if (pollMode) sel.quad = pollPtr;
    else               sel.quad = dirQuad;
    sel.first = (sel.quad == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollPtr <= '0;
      dirQuad <= '0;
    end else begin
      if (quadAddrEn) dirQuad <= quadAddr;
      if (singleQuad)    pollPtr <= QW'(1);
      else if (pollMode) pollPtr <= pollPtr + 1'b1;
    end
  end
endmodule

// File: rtl/qflag_path.sv
module qflag_path
  import qflag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [QUEUES-1:0] flags,
  input  logic [CW-1:0]     activeQueues,
  input  quadSel_t          sel,
  output logic [LANES-1:0]  bus,
  output logic [QW-1:0]     quadOut,
  output logic              strobe
);
  logic [LANES-1:0] nextBus;
  logic [CW-1:0]    quadBase;

  assign quadBase = CW'(sel.quad) * CW'(LANES);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [CW-1:0] qIdx;
    assign qIdx = quadBase + CW'(lane);
    assign nextBus[lane] = (qIdx < activeQueues) ? flags[qIdx[IW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bus     <= '0;
      quadOut <= '0;
      strobe  <= 1'b0;
    end else begin
      bus     <= nextBus;
      quadOut <= sel.quad;
      strobe  <= sel.first;
    end
  end
endmodule

// File: rtl/qflag_mux.sv
module qflag_mux
  import qflag_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              pollMode,
  input  logic [CW-1:0]     activeQueues,
  input  logic [QUEUES-1:0] afFlags,
  input  logic [QUEUES-1:0] aeFlags,
  input  logic [QW-1:0]     wrQuadAddr,
  input  logic              wrQuadAddrEn,
  input  logic [QW-1:0]     rdQuadAddr,
  input  logic              rdQuadAddrEn,
  output logic [LANES-1:0]  afBus,
  output logic [QW-1:0]     afQuad,
  output logic              afStrobe,
  output logic [LANES-1:0]  aeBus,
  output logic [QW-1:0]     aeQuad,
  output logic              aeStrobe
);
  quadSel_t wSel;
  quadSel_t rSel;

  qflag_ctrl u_wCtrl (
    .clk(wrClk), .rstN(rstN), .pollMode(pollMode), .activeQueues(activeQueues),
    .quadAddr(wrQuadAddr), .quadAddrEn(wrQuadAddrEn), .sel(wSel)
  );

  qflag_path u_wPath (
    .clk(wrClk), .rstN(rstN), .flags(afFlags), .activeQueues(activeQueues),
    .sel(wSel), .bus(afBus), .quadOut(afQuad), .strobe(afStrobe)
  );

  qflag_ctrl u_rCtrl (
    .clk(rdClk), .rstN(rstN), .pollMode(pollMode), .activeQueues(activeQueues),
    .quadAddr(rdQuadAddr), .quadAddrEn(rdQuadAddrEn), .sel(rSel)
  );

  qflag_path u_rPath (
    .clk(rdClk), .rstN(rstN), .flags(aeFlags), .activeQueues(activeQueues),
    .sel(rSel), .bus(aeBus), .quadOut(aeQuad), .strobe(aeStrobe)
  );
endmodule

// File: rtl/qflag_chk.sv
module qflag_chk
  import qflag_pkg::*;
(
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              pollMode,
  input logic [CW-1:0]     activeQueues,
  input logic [QUEUES-1:0] afFlags,
  input logic [QUEUES-1:0] aeFlags,
  input logic [QW-1:0]     wrQuadAddr,
  input logic              wrQuadAddrEn,
  input logic [QW-1:0]     rdQuadAddr,
  input logic              rdQuadAddrEn,
  input logic [LANES-1:0]  afBus,
  input logic [QW-1:0]     afQuad,
  input logic              afStrobe,
  input logic [LANES-1:0]  aeBus,
  input logic [QW-1:0]     aeQuad,
  input logic              aeStrobe
);
  logic [1:0] wSeen;
  logic [1:0] rSeen;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wSeen <= '0;
    else if (wSeen != 2'd3) wSeen <= wSeen + 1'b1;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rSeen <= '0;
    else if (rSeen != 2'd3) rSeen <= rSeen + 1'b1;
  end

  function automatic logic [LANES-1:0] expSlice(input logic [QUEUES-1:0] f,
                                                input logic [QW-1:0] q,
                                                input logic [CW-1:0] n);
    logic [LANES-1:0] r;
    for (int b = 0; b < LANES; b++) begin
      logic [CW-1:0] idx;
      idx = CW'(q) * CW'(LANES) + CW'(b);
      r[b] = (idx < n) ? f[idx[IW-1:0]] : 1'b0;
    end
    return r;
  endfunction

  // R2
  af_slice_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wSeen != 2'd0) |-> (afBus == expSlice($past(afFlags), afQuad, $past(activeQueues))));
  // R2
  ae_slice_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rSeen != 2'd0) |-> (aeBus == expSlice($past(aeFlags), aeQuad, $past(activeQueues))));
  // R3
  af_poll_step_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    ((wSeen >= 2'd2) && $past(pollMode) && $past(pollMode, 2) &&
     ($past(activeQueues) > CW'(LANES)) && ($past(activeQueues, 2) > CW'(LANES)))
    |-> (afQuad == ($past(afQuad) + 1'b1)));
  // R3
  ae_poll_step_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    ((rSeen >= 2'd2) && $past(pollMode) && $past(pollMode, 2) &&
     ($past(activeQueues) > CW'(LANES)) && ($past(activeQueues, 2) > CW'(LANES)))
    |-> (aeQuad == ($past(aeQuad) + 1'b1)));
  // R4
  af_strobe_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wSeen != 2'd0) |-> (afStrobe == (afQuad == '0)));
  // R4
  ae_strobe_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rSeen != 2'd0) |-> (aeStrobe == (aeQuad == '0)));
  // R5
  af_direct_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    ((wSeen >= 2'd2) && !$past(pollMode) && ($past(activeQueues) > CW'(LANES)) &&
     $past(wrQuadAddrEn, 2)) |-> (afQuad == $past(wrQuadAddr, 2)));
  // R5
  ae_direct_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    ((rSeen >= 2'd2) && !$past(pollMode) && ($past(activeQueues) > CW'(LANES)) &&
     $past(rdQuadAddrEn, 2)) |-> (aeQuad == $past(rdQuadAddr, 2)));
  // R8
  af_single_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    ((wSeen != 2'd0) && ($past(activeQueues) <= CW'(LANES))) |-> (afQuad == '0));
  // R8
  ae_single_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    ((rSeen != 2'd0) && ($past(activeQueues) <= CW'(LANES))) |-> (aeQuad == '0));
endmodule

bind qflag_mux qflag_chk u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .pollMode(pollMode),
  .activeQueues(activeQueues), .afFlags(afFlags), .aeFlags(aeFlags),
  .wrQuadAddr(wrQuadAddr), .wrQuadAddrEn(wrQuadAddrEn),
  .rdQuadAddr(rdQuadAddr), .rdQuadAddrEn(rdQuadAddrEn),
  .afBus(afBus), .afQuad(afQuad), .afStrobe(afStrobe),
  .aeBus(aeBus), .aeQuad(aeQuad), .aeStrobe(aeStrobe)
);

// File: tb/qflag_mux_tb.sv
`timescale 1ns/1ps
module qflag_mux_tb;
  logic        wrClk = 1'b0;
  logic        rdClk = 1'b0;
  logic        rstN = 1'b0;
  logic        pollMode = 1'b1;
  logic [5:0]  activeQueues = 6'd32;
  logic [31:0] afFlags = 32'hA5C3_5A3C;
  logic [31:0] aeFlags = 32'h1234_F0E1;
  logic [1:0]  wrQuadAddr = '0;
  logic        wrQuadAddrEn = 1'b0;
  logic [1:0]  rdQuadAddr = '0;
  logic        rdQuadAddrEn = 1'b0;
  logic [7:0]  afBus, aeBus;
  logic [1:0]  afQuad, aeQuad;
  logic        afStrobe, aeStrobe;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  qflag_mux u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .pollMode(pollMode),
    .activeQueues(activeQueues), .afFlags(afFlags), .aeFlags(aeFlags),
    .wrQuadAddr(wrQuadAddr), .wrQuadAddrEn(wrQuadAddrEn),
    .rdQuadAddr(rdQuadAddr), .rdQuadAddrEn(rdQuadAddrEn),
    .afBus(afBus), .afQuad(afQuad), .afStrobe(afStrobe),
    .aeBus(aeBus), .aeQuad(aeQuad), .aeStrobe(aeStrobe)
  );

  always #4 wrClk = ~wrClk;
  initial begin
    #3;
    forever #4 rdClk = ~rdClk;
  end

  function automatic logic [7:0] expBus(input logic [31:0] f, input int q, input int n);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = ((q * 8 + b) < n) ? f[q * 8 + b] : 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wTick();
    @(posedge wrClk);
    #2;
  endtask

  task automatic rTick();
    @(posedge rdClk);
    #2;
  endtask

  task automatic test_reset();
    #30;
    chk("R1 afBus", afBus, 0);
    chk("R1 afQuad", afQuad, 0);
    chk("R1 afStrobe", afStrobe, 0);
    chk("R1 aeBus", aeBus, 0);
    chk("R1 aeQuad", aeQuad, 0);
    chk("R1 aeStrobe", aeStrobe, 0);
    #20 rstN = 1'b1;
  endtask

  task automatic test_polled_write();
    wTick();
    chk("R3 first edge afQuad", afQuad, 0);
    chk("R4 first edge afStrobe", afStrobe, 1);
    chk("R2 afBus q0", afBus, expBus(afFlags, 0, 32));
    for (int k = 1; k < 7; k++) begin
      wTick();
      chk("R3 afQuad step", afQuad, k % 4);
      chk("R2 afBus slice", afBus, expBus(afFlags, k % 4, 32));
      chk("R4 afStrobe", afStrobe, (k % 4) == 0);
    end
  endtask

  task automatic test_polled_read();
    int q;
    rTick();
    q = aeQuad;
    for (int k = 0; k < 5; k++) begin
      rTick();
      q = (q + 1) % 4;
      chk("R3 aeQuad step", aeQuad, q);
      chk("R2 aeBus slice", aeBus, expBus(aeFlags, q, 32));
      chk("R4 aeStrobe", aeStrobe, q == 0);
    end
    aeFlags = 32'h0F0F_9966;
    rTick();
    q = (q + 1) % 4;
    chk("R2 aeBus follows new flags", aeBus, expBus(aeFlags, q, 32));
  endtask

  task automatic test_direct();
    wTick();
    pollMode = 1'b0;
    wrQuadAddr = 2'd2;
    wrQuadAddrEn = 1'b1;
    wTick();
    wrQuadAddrEn = 1'b0;
    wrQuadAddr = 2'd1;
    wTick();
    chk("R5 afQuad direct", afQuad, 2);
    chk("R5 afBus direct", afBus, expBus(afFlags, 2, 32));
    wTick();
    chk("R5 afQuad held without enable", afQuad, 2);
    rTick();
    rdQuadAddr = 2'd3;
    rdQuadAddrEn = 1'b1;
    rTick();
    rdQuadAddrEn = 1'b0;
    rdQuadAddr = 2'd0;
    rTick();
    chk("R5 aeQuad direct", aeQuad, 3);
    chk("R5 aeBus direct", aeBus, expBus(aeFlags, 3, 32));
    wTick();
    chk("R6 afQuad unaffected by read address", afQuad, 2);
    rTick();
    chk("R6 aeQuad held", aeQuad, 3);
  endtask

  task automatic test_mask();
    int q;
    wTick();
    pollMode = 1'b1;
    activeQueues = 6'd20;
    afFlags = 32'hFFFF_FFFF;
    wTick();
    q = afQuad;
    chk("R7 afBus masked", afBus, expBus(afFlags, q, 20));
    for (int k = 0; k < 4; k++) begin
      wTick();
      q = (q + 1) % 4;
      chk("R7 afQuad still cycles", afQuad, q);
      chk("R7 afBus masked", afBus, expBus(afFlags, q, 20));
    end
  endtask

  task automatic test_small();
    wTick();
    activeQueues = 6'd5;
    afFlags = 32'hFFFF_FFF6;
    wTick();
    for (int k = 0; k < 3; k++) begin
      wTick();
      chk("R8 afQuad pinned polled", afQuad, 0);
      chk("R8 afBus single", afBus, 8'h16);
      chk("R4 afStrobe pinned", afStrobe, 1);
    end
    pollMode = 1'b0;
    wrQuadAddr = 2'd3;
    wrQuadAddrEn = 1'b1;
    wTick();
    wrQuadAddrEn = 1'b0;
    wTick();
    wTick();
    chk("R8 afQuad pinned direct", afQuad, 0);
    rTick();
    chk("R8 aeQuad pinned direct", aeQuad, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_polled_write();
    test_polled_read();
    test_direct();
    test_mask();
    test_small();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule